// File: doc/BRIEF.md
# Capture/Compare Timer

A timer/counter block with a programmable power-of-two prescaler and a bank of capture/compare channels. Single-cycle task strobes start, stop, power down, clear and step the counter, and copy its value into a channel on demand. Each channel sets a sticky match flag when the counter advances onto its compare value. It also emits a one-cycle event strobe for the event routing that sits outside the block. Per-channel shortcuts can clear or halt the counter on a match. Per-channel interrupt enables are gated with the flags to form one interrupt line. A channel in single-fire mode matches once and then stays quiet until software rewrites its compare value.

Software configures the block through a small word-addressed register port. Writes take effect at the clock edge. Reads are returned one cycle after the read strobe. Counter width (8/16/24/32 bits), counting source (prescaled clock or count strobe) and prescale exponent are set in a control word.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter is stopped at 0. The control word, all compare values, match flags, interrupt enables, shortcuts and single-fire enables read 0, and `irq` and `evt_cmp` are low.
- R2: With mode code 0 (timer), the counter advances once every 2^P clocks while running, where P is control bits [7:4]. The first advance comes 2^P edges after the start edge when the phase is 0.
- R3: A prescale value above 9 written to control bits [7:4] is stored and read back as 9.
- R4: With mode code 1 or 2 (counting) in control bits [1:0], the counter advances by one per `tsk_count` strobe, and only while running. Strobes while stopped and elapsed clocks have no effect.
- R5: Control bits [3:2] select the width: 0=8, 1=16, 2=24, 3=32 bits. The counter wraps to 0 at that width, and compare values are matched on their low bits of that width.
- R6: A `tsk_capture[n]` strobe copies the counter value before that edge into channel n's compare register (word 0x10+n). A capture wins over a software write in the same cycle.
- R7: When the counter advances to channel n's compare value, the flag at word 0x20+n becomes 1 and `evt_cmp[n]` pulses for exactly one cycle. The flag is not set again while the counter rests on that value. Writing a word with bit 0 = 0 clears the flag; writing bit 0 = 1 has no effect.
- R8: With shortcut bit n (word 0x01, bit n) set, a match on channel n clears the counter to 0 on the following edge. A count strobe on that edge is lost.
- R9: With shortcut bit 8+n (word 0x01) set, a match on channel n stops the counter on the following edge, and the counter holds the matched value.
- R10: Writing 1s to word 0x02 sets interrupt enable bits and writing 1s to word 0x03 clears them. Both words read back the enable mask. `irq` is high exactly when some channel has both its flag and its enable set.
- R11: With single-fire bit n (word 0x04) set, channel n matches only once after its compare value was last written. Later passes over the value set no flag, until software writes the compare value again.
- R12: `tsk_clear` zeroes the counter. `tsk_stop` halts the counter and keeps both its value and the prescaler phase. `tsk_shutdown` halts the counter and resets the prescaler phase to 0. Stop or shutdown wins over start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tsk_start | input | 1 | Start strobe |
| tsk_stop | input | 1 | Stop strobe (keeps value and phase) |
| tsk_count | input | 1 | Count strobe, used in counting mode |
| tsk_clear | input | 1 | Clear-counter strobe |
| tsk_shutdown | input | 1 | Stop and reset prescaler phase |
| tsk_capture | input | NCH | Per-channel capture strobes |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High one cycle after reg_re |
| evt_cmp | output | NCH | One-cycle compare event strobes |
| irq | output | 1 | Interrupt request |

## Verification
Strobes and writes are sampled at one edge. A counting strobe changes the counter at that edge, and a compare match raises its flag and event strobe at that same edge. A shortcut acts one edge later, and read data appears one edge after the read strobe. The bench drives every input at the falling edge and samples directly-observed outputs at the next falling edge. It queues each read's expected word for a monitor that pops it when `reg_rvalid` rises. Timer-mode values are predicted by counting edges from the start edge: with exponent P and zero phase, the counter equals floor(k/2^P) after edge k.

// File: rtl/tmr_pkg.sv
// Package: shared register word addresses, mode and width codes for the
// capture/compare timer. Assumes at most 8 channels per instance.
package tmr_pkg;

    localparam int unsigned A_CTRL     = 'h00;
    localparam int unsigned A_SHORTCUT = 'h01;
    localparam int unsigned A_IEN_SET  = 'h02;
    localparam int unsigned A_IEN_CLR  = 'h03;
    localparam int unsigned A_ONESHOT  = 'h04;
    localparam int unsigned A_CC_BASE  = 'h10;
    localparam int unsigned A_FLG_BASE = 'h20;

    // Bit position of the first stop shortcut inside the shortcut word.
    localparam int unsigned STOP_SHIFT = 8;

    typedef enum logic [1:0] {
        MD_TIMER   = 2'd0,
        MD_COUNT   = 2'd1,
        MD_LPCOUNT = 2'd2,
        MD_RSVD    = 2'd3
    } tmr_mode_e;

    // Mask of valid counter bits for a width code.
    function automatic logic [31:0] width_mask(input logic [1:0] code);
        case (code)
            2'd0:    width_mask = 32'h0000_00FF;
            2'd1:    width_mask = 32'h0000_FFFF;
            2'd2:    width_mask = 32'h00FF_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: divides the clock by 2^ps while enabled and emits one tick per
// period. Assumes ps never exceeds PS_MAX (clamped by the register file).
// The phase counter is held while not advancing and cleared on phase reset.
module tmr_prescaler #(
    parameter int PSW    = 4,
    parameter int PS_MAX = 9,
    localparam int PCW   = PS_MAX + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           advance,
    input  logic           reset_phase,
    input  logic [PSW-1:0] ps,
    output logic           tick
);
    logic [PCW-1:0] phase;
    logic [PCW-1:0] limit;

    // Terminal count of the current division ratio.
    always_comb limit = (PCW'(1) << ps) - PCW'(1);

    // A tick when the phase reaches (or stands above, after a ratio change) the limit.
    always_comb tick = advance && (phase >= limit);

    // Phase counter update.
    always_ff @(posedge clk) begin
        if (!rst_n)           phase <= '0;
        else if (reset_phase) phase <= '0;
        else if (advance)     phase <= (phase >= limit) ? '0 : phase + PCW'(1);
    end

    p_phase_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reset_phase |=> (phase == '0));

    p_phase_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !reset_phase) |=> $stable(phase));

endmodule

// File: rtl/tmr_core.sv
// Counter core: run state, counter register and its clear/stop priority.
// Assumes hit_q holds the registered compare matches of the previous edge, so
// shortcuts act one edge after the match. Clear beats increment; halt beats start.
module tmr_core #(
    parameter int CW  = 32,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tsk_start,
    input  logic           tsk_stop,
    input  logic           tsk_count,
    input  logic           tsk_clear,
    input  logic           tsk_shutdown,
    input  logic           is_counting,
    input  logic           tick,
    input  logic [CW-1:0]  wmask,
    input  logic [NCH-1:0] hit_q,
    input  logic [NCH-1:0] sh_clr,
    input  logic [NCH-1:0] sh_stop,
    output logic           run,
    output logic [CW-1:0]  cnt,
    output logic [CW-1:0]  cnt_nxt,
    output logic           inc,
    output logic           clear_now,
    output logic           advance,
    output logic           phase_rst
);
    logic halt;

    // Sources that halt or zero the counter this cycle.
    always_comb begin
        halt      = tsk_stop || tsk_shutdown || (|(hit_q & sh_stop));
        clear_now = tsk_clear || (|(hit_q & sh_clr));
        phase_rst = tsk_shutdown;
    end

    // Increment qualification for either counting source.
    always_comb begin
        advance = run && !halt && !is_counting;
        inc     = run && !halt && (is_counting ? tsk_count : tick);
        cnt_nxt = (cnt + CW'(1)) & wmask;
    end

    // Run state: halt wins over start.
    always_ff @(posedge clk) begin
        if (!rst_n)         run <= 1'b0;
        else if (halt)      run <= 1'b0;
        else if (tsk_start) run <= 1'b1;
    end

    // Counter register: clear wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (clear_now) cnt <= '0;
        else if (inc)       cnt <= cnt_nxt;
    end

    p_stopped_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear_now) |=> (cnt == $past(cnt)));

    p_clear_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tsk_clear |=> (cnt == '0));

    p_halt_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tsk_stop || tsk_shutdown) |=> !run);

    p_stop_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit_q & sh_stop)) |=> !run);

endmodule

// File: rtl/tmr_channel.sv
// Capture/compare channel: compare register, capture, single-fire arming,
// match detection, registered event strobe and sticky flag.
// Assumes cnt is already within wmask; a match needs an actual advance.
module tmr_channel #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cc_we,
    input  logic [CW-1:0] cc_wdata,
    input  logic          capture,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cnt_nxt,
    input  logic          inc,
    input  logic          clear_now,
    input  logic [CW-1:0] wmask,
    input  logic          oneshot_en,
    input  logic          flag_clr,
    output logic [CW-1:0] cc,
    output logic          hit_q,
    output logic          flag
);
    logic armed;
    logic hit;

    // Match when the counter advances onto the masked compare value.
    always_comb hit = inc && !clear_now && (armed || !oneshot_en)
                      && (cnt_nxt == (cc & wmask));

    // Compare register: capture wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cc <= '0;
        else if (capture) cc <= cnt & wmask;
        else if (cc_we)   cc <= cc_wdata;
    end

    // Single-fire arming: armed by a compare write, spent by a match.
    always_ff @(posedge clk) begin
        if (!rst_n)                   armed <= 1'b1;
        else if (cc_we && !capture)   armed <= 1'b1;
        else if (hit && oneshot_en)   armed <= 1'b0;
    end

    // Event strobe and sticky flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            hit_q <= hit;
            if (hit)           flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cc_we && !capture) |=> !hit);

    p_oneshot_spent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_en && !armed) |-> !hit);

endmodule

// File: rtl/cc_timer.sv
// Capture/compare timer top: register file, prescaler, counter core and a
// generated bank of channels. Reads are registered (one-cycle latency).
// Assumes 1 <= NCH <= 8, CW <= DW and AW wide enough for word 0x20+NCH-1.
module cc_timer
    import tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CW     = 32,
    parameter int DW     = 32,
    parameter int AW     = 8,
    parameter int PS_MAX = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tsk_start,
    input  logic           tsk_stop,
    input  logic           tsk_count,
    input  logic           tsk_clear,
    input  logic           tsk_shutdown,
    input  logic [NCH-1:0] tsk_capture,
    input  logic           reg_we,
    input  logic           reg_re,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           reg_rvalid,
    output logic [NCH-1:0] evt_cmp,
    output logic           irq
);
    localparam int PSW = 4;

    // Configuration state.
    logic [1:0]     md;
    logic [1:0]     wcode;
    logic [PSW-1:0] ps;
    logic [NCH-1:0] sh_clr, sh_stop, ien, oneshot;

    // Datapath nets.
    logic           run, inc, clear_now, advance, phase_rst, tick, is_counting;
    logic [CW-1:0]  cnt, cnt_nxt, wmask;
    logic [CW-1:0]  cc_val [NCH];
    logic [NCH-1:0] hit_q, flag, cc_we, flag_clr;
    logic [DW-1:0]  rd_word;

    // Decoded mode and width.
    always_comb begin
        is_counting = (md == MD_COUNT) || (md == MD_LPCOUNT);
        wmask       = CW'(width_mask(wcode));
    end

    // Control and channel-wide configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md      <= '0;
            wcode   <= '0;
            ps      <= '0;
            sh_clr  <= '0;
            sh_stop <= '0;
            ien     <= '0;
            oneshot <= '0;
        end else if (reg_we) begin
            if (reg_addr == AW'(A_CTRL)) begin
                md    <= reg_wdata[1:0];
                wcode <= reg_wdata[3:2];
                ps    <= (reg_wdata[7:4] > PSW'(PS_MAX)) ? PSW'(PS_MAX) : reg_wdata[7:4];
            end
            if (reg_addr == AW'(A_SHORTCUT)) begin
                sh_clr  <= reg_wdata[NCH-1:0];
                sh_stop <= reg_wdata[STOP_SHIFT +: NCH];
            end
            if (reg_addr == AW'(A_IEN_SET)) ien <= ien | reg_wdata[NCH-1:0];
            if (reg_addr == AW'(A_IEN_CLR)) ien <= ien & ~reg_wdata[NCH-1:0];
            if (reg_addr == AW'(A_ONESHOT)) oneshot <= reg_wdata[NCH-1:0];
        end
    end

    // Per-channel write decode.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cc_we[i]    = reg_we && (reg_addr == AW'(A_CC_BASE + i));
            flag_clr[i] = reg_we && (reg_addr == AW'(A_FLG_BASE + i)) && !reg_wdata[0];
        end
    end

    tmr_prescaler #(.PSW(PSW), .PS_MAX(PS_MAX)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (advance),
        .reset_phase (phase_rst),
        .ps          (ps),
        .tick        (tick)
    );

    tmr_core #(.CW(CW), .NCH(NCH)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tsk_start    (tsk_start),
        .tsk_stop     (tsk_stop),
        .tsk_count    (tsk_count),
        .tsk_clear    (tsk_clear),
        .tsk_shutdown (tsk_shutdown),
        .is_counting  (is_counting),
        .tick         (tick),
        .wmask        (wmask),
        .hit_q        (hit_q),
        .sh_clr       (sh_clr),
        .sh_stop      (sh_stop),
        .run          (run),
        .cnt          (cnt),
        .cnt_nxt      (cnt_nxt),
        .inc          (inc),
        .clear_now    (clear_now),
        .advance      (advance),
        .phase_rst    (phase_rst)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cc_we      (cc_we[g]),
            .cc_wdata   (reg_wdata[CW-1:0]),
            .capture    (tsk_capture[g]),
            .cnt        (cnt),
            .cnt_nxt    (cnt_nxt),
            .inc        (inc),
            .clear_now  (clear_now),
            .wmask      (wmask),
            .oneshot_en (oneshot[g]),
            .flag_clr   (flag_clr[g]),
            .cc         (cc_val[g]),
            .hit_q      (hit_q[g]),
            .flag       (flag[g])
        );
    end

    // Outputs toward the event routing and the interrupt controller.
    always_comb begin
        evt_cmp = hit_q;
        irq     = |(flag & ien);
    end

    // Read multiplexer.
    always_comb begin
        rd_word = '0;
        if (reg_addr == AW'(A_CTRL))     rd_word = DW'({ps, wcode, md});
        if (reg_addr == AW'(A_SHORTCUT)) rd_word = (DW'(sh_stop) << STOP_SHIFT) | DW'(sh_clr);
        if (reg_addr == AW'(A_IEN_SET) || reg_addr == AW'(A_IEN_CLR)) rd_word = DW'(ien);
        if (reg_addr == AW'(A_ONESHOT))  rd_word = DW'(oneshot);
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == AW'(A_CC_BASE + i))  rd_word = DW'(cc_val[i]);
            if (reg_addr == AW'(A_FLG_BASE + i)) rd_word = DW'(flag[i]);
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_re;
            if (reg_re) reg_rdata <= rd_word;
        end
    end

    p_prescale_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ps <= PSW'(PS_MAX));

    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> reg_rvalid);

endmodule

// File: tb/cc_timer_test.sv
module cc_timer_test;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tsk_start = 0, tsk_stop = 0, tsk_count = 0, tsk_clear = 0, tsk_shutdown = 0;
    logic [NCH-1:0] tsk_capture = '0;
    logic reg_we = 0, reg_re = 0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [NCH-1:0] evt_cmp;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mon_e;
    string       mon_t;

    cc_timer #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n),
        .tsk_start(tsk_start), .tsk_stop(tsk_stop), .tsk_count(tsk_count),
        .tsk_clear(tsk_clear), .tsk_shutdown(tsk_shutdown), .tsk_capture(tsk_capture),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .evt_cmp(evt_cmp), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected word for every returned read.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL unexpected read actual=%0h expected=none", reg_rdata);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                chk(mon_t, reg_rdata, mon_e);
            end
        end
    end

    // All tasks start and end at a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        reg_re = 1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_re = 0;
    endtask
    task automatic p_start();    tsk_start = 1;    @(negedge clk); tsk_start = 0;    endtask
    task automatic p_stop();     tsk_stop = 1;     @(negedge clk); tsk_stop = 0;     endtask
    task automatic p_clear();    tsk_clear = 1;    @(negedge clk); tsk_clear = 0;    endtask
    task automatic p_shutdown(); tsk_shutdown = 1; @(negedge clk); tsk_shutdown = 0; endtask
    task automatic p_count(input int n);
        for (int i = 0; i < n; i++) begin
            tsk_count = 1; @(negedge clk); tsk_count = 0;
        end
    endtask
    task automatic p_cap(input int ch);
        tsk_capture[ch] = 1'b1; @(negedge clk); tsk_capture = '0;
    endtask
    task automatic clr_flags();
        for (int i = 0; i < NCH; i++) wr(8'h20 + 8'(i), 32'h0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 evt", 32'(evt_cmp), 0);
        rd(8'h00, 0, "R1 ctrl");
        rd(8'h10, 0, "R1 cc0");
        rd(8'h20, 0, "R1 flag0");
        rd(8'h02, 0, "R1 ien");
        rd(8'h01, 0, "R1 shortcut");
        p_cap(0);
        rd(8'h10, 0, "R1 counter zero via capture");

        // R3 prescale clamp: ps=12, width 3, timer
        wr(8'h00, 32'hCC);
        rd(8'h00, 32'h9C, "R3 clamp");

        // R2 timer ps=2: counter = floor(10/4)
        wr(8'h00, 32'h2C);
        p_clear(); p_start(); idle(10); p_cap(0);
        rd(8'h10, 2, "R2 ps2");
        p_stop();
        // R2 ps=0: one per clock
        wr(8'h00, 32'h0C);
        p_clear(); p_start(); idle(5); p_cap(1);
        rd(8'h11, 5, "R2 ps0");
        p_stop();

        // R12 shutdown resets phase
        wr(8'h00, 32'h2C);
        p_shutdown(); p_clear(); p_start(); idle(6); p_shutdown();
        p_start(); idle(3); p_cap(2);
        rd(8'h12, 1, "R12 shutdown phase");
        // R12 stop keeps phase and value
        p_shutdown(); p_clear(); p_start(); idle(6); p_stop();
        idle(4); p_cap(3);
        rd(8'h13, 1, "R12 stop holds value");
        p_start(); idle(3); p_cap(2);
        rd(8'h12, 2, "R12 stop keeps phase");
        p_shutdown();

        // R4 counting mode
        wr(8'h00, 32'h0D);
        p_clear(); p_count(3); p_cap(0);
        rd(8'h10, 0, "R4 counts ignored while stopped");
        p_start(); p_count(3); idle(10); p_cap(0);
        rd(8'h10, 3, "R4 counted three");

        // R7 flag and event strobe
        clr_flags();
        wr(8'h11, 5);
        p_count(1);
        chk("R7 no event at 4", 32'(evt_cmp), 0);
        p_count(1);
        chk("R7 event at 5", 32'(evt_cmp), 32'h2);
        idle(1);
        chk("R7 event one cycle", 32'(evt_cmp), 0);
        rd(8'h21, 1, "R7 flag set");
        wr(8'h21, 1);
        rd(8'h21, 1, "R7 write one ignored");
        wr(8'h21, 0);
        idle(3);
        rd(8'h21, 0, "R7 cleared and not reset while resting");

        // R10 interrupts
        wr(8'h02, 32'h2);
        rd(8'h02, 2, "R10 set read");
        rd(8'h03, 2, "R10 clr read");
        chk("R10 irq idle", 32'(irq), 0);
        wr(8'h11, 7);
        p_count(2);
        chk("R10 irq on", 32'(irq), 1);
        wr(8'h03, 32'h2);
        chk("R10 irq masked", 32'(irq), 0);
        rd(8'h02, 0, "R10 cleared mask");
        wr(8'h02, 32'h2);
        chk("R10 irq re-enabled", 32'(irq), 1);
        wr(8'h21, 0);
        chk("R10 irq flag cleared", 32'(irq), 0);
        wr(8'h03, 32'hF);

        // R5 8-bit wrap
        wr(8'h00, 32'h01);
        p_clear(); clr_flags();
        wr(8'h10, 32'h105);
        p_count(5);
        rd(8'h20, 1, "R5 masked compare");
        wr(8'h20, 0);
        p_count(251); p_cap(1);
        rd(8'h11, 0, "R5 wrap to zero");
        p_count(5);
        rd(8'h20, 1, "R5 match after wrap");

        // R8 clear shortcut
        wr(8'h00, 32'h0D);
        p_clear();
        wr(8'h11, 3); wr(8'h01, 32'h2);
        p_count(3); idle(1); p_count(2); p_cap(0);
        rd(8'h10, 2, "R8 clear shortcut");
        wr(8'h01, 0);

        // R9 stop shortcut
        p_clear(); clr_flags();
        wr(8'h12, 4); wr(8'h01, 32'h400);
        p_count(6); p_cap(0);
        rd(8'h10, 4, "R9 stop holds match value");
        rd(8'h22, 1, "R9 flag");
        wr(8'h01, 0);

        // R11 single fire
        p_start(); p_clear();
        wr(8'h04, 32'h8); wr(8'h13, 2); wr(8'h23, 0);
        p_count(2);
        rd(8'h23, 1, "R11 first match");
        wr(8'h23, 0);
        p_clear(); p_count(2);
        rd(8'h23, 0, "R11 spent");
        wr(8'h13, 2);
        p_clear(); p_count(2);
        rd(8'h23, 1, "R11 rearmed");

        // R6 capture wins over write; R12 clear zeroes
        reg_we = 1; reg_addr = 8'h10; reg_wdata = 32'h55; tsk_capture = 4'h1;
        @(negedge clk);
        reg_we = 0; tsk_capture = '0;
        rd(8'h10, 2, "R6 capture beats write");
        p_clear(); p_cap(0);
        rd(8'h10, 0, "R12 clear zeroes");

        idle(3);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule